// File: doc/BRIEF.md
# Four-Channel Input Capture Timer

This block is a 16-bit up-counter with four capture channels, A to D. It measures the width or the period of external pulses. Each channel watches one input line. On an edge of the chosen polarity, the channel copies the present counter value into its own capture register. Software then subtracts two captured values to get a width or a period. The counter advances by one on every cycle in which the count-enable strobe `cnt_tick` is high and the run bit is set. It either wraps freely through 16 bits, or it returns to zero when it matches the value held in capture register A. In the second case, register A sets the period as well as serving as a capture register.

Channel A can take its trigger from an internal signal `alt_trig` in place of its pin. Every event (overflow, and a capture on each channel) sets a sticky flag. The enabled flags are combined into one interrupt line. All state is reached through a small word-wide register port. Writes take effect on the clock edge, and reads are combinational.

Register map (4-bit address, 16-bit data):
- 0 CTRL: bit0 run, bit1 clear-on-match, bit2 channel A uses `alt_trig`.
- 1 CHCFG: channel k uses bits [3k+2:3k]. Bit 3k enables the channel. Bits [3k+2:3k+1] select the edge: 00 none, 01 rising, 10 falling, 11 both.
- 2 COUNT: the counter.
- 3 FLAGS: bit0 overflow, bit k+1 capture on channel k. Writing 1 to a bit clears it.
- 4 IRQEN: enable bits laid out the same way as FLAGS.
- 8 to 11: capture registers for channels A to D.

Top module: `quad_capture_timer`

## Requirements
- R1: After reset, the counter, all capture registers, CTRL, CHCFG, FLAGS and IRQEN read 0, and `irq` is low.
- R2: While CTRL bit0 is 1, each cycle with `cnt_tick` high adds one to the counter. While CTRL bit0 is 0, the counter holds its value whatever `cnt_tick` does.
- R3: With clear-on-match off, an increment from FFFFh gives 0000h and sets FLAGS bit0.
- R4: With CTRL bit1 set, a tick that finds the counter equal to capture register A loads 0000h instead of incrementing. The count period is therefore n+1 ticks, where n is the value of register A.
- R5: Channel k, when enabled with edge code 01, copies the counter into capture register k on a rising input edge and sets FLAGS bit k+1. The register changes on the third rising clock edge after the input changes.
- R6: Edge code 10 captures only on falling edges and code 11 captures on both edges. A disabled channel, or one with code 00, never captures, and a rising-only channel ignores falling edges.
- R7: With CTRL bit2 set, channel A takes its trigger from `alt_trig`, and edges on `cap_in[0]` are ignored.
- R8: Input edges that occur while CTRL bit0 is 0 cause no capture and set no flag, including after counting resumes.
- R9: Flags stay set until software writes 1 to them. `irq` is high exactly when some flag is set and its IRQEN bit is 1.
- R10: Software can write and read back the counter and the capture registers. When a capture and a counter write fall in the same cycle, the capture stores the value the counter held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count-enable strobe |
| cap_in | input | 4 | Capture inputs for channels A to D (asynchronous) |
| alt_trig | input | 1 | Alternative trigger for channel A |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a capture strobe and a software write to the counter landing in the same cycle. The capture strobe comes out of a two-flop synchronizer and an edge detector, so its cycle is set by the pipeline and not by any port. The bench holds `cnt_tick` low so that the counter is static. It changes a pin on a falling clock edge, counts two rising edges, and then presents the counter write in exactly the cycle of the strobe. It then checks that the capture register holds the old counter value and the counter holds the new one. The edges-while-stopped case is reached the same way: the run bit is cleared before the pin moves, and the pin is left high after counting resumes.

// File: rtl/qct_pkg.sv
package qct_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] ADDR_CHCFG = 4'd1;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 4'd2;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 4'd3;
    localparam logic [ADDR_W-1:0] ADDR_IRQEN = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_CAP0  = 4'd8;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // Packed so that bit 0 is the enable and bits 2:1 are the edge code
    typedef struct packed {
        edge_sel_e edge_sel;
        logic      en;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    typedef struct packed {
        logic alt_a;
        logic clr_match;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/qct_counter.sv
module qct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         clr_mode,
    input  logic [W-1:0] match_val,
    input  logic         sw_we,
    input  logic [W-1:0] sw_data,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic advance;
    logic match;

    always_comb begin
        st_d    = st_q;
        advance = run & tick;
        match   = clr_mode & (st_q.cnt == match_val);
        ovf     = 1'b0;
        if (sw_we) begin
            st_d.cnt = sw_data;
        end else if (advance) begin
            if (match) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                ovf      = (st_q.cnt == ALL_ONES);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/qct_cap_chan.sv
module qct_cap_chan
    import qct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin,
    input  logic         run,
    input  chan_cfg_t    cfg,
    input  logic         sw_we,
    input  logic [W-1:0] sw_data,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cap,
    output logic         cap_hit
);
    typedef struct packed {
        logic         sync1;
        logic         sync2;
        logic         prev;
        logic [W-1:0] cap;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic rise, fall, edge_ok;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = pin;
        st_d.sync2 = st_q.sync1;
        st_d.prev  = st_q.sync2;
        rise       = st_q.sync2 & ~st_q.prev;
        fall       = ~st_q.sync2 & st_q.prev;
        unique case (cfg.edge_sel)
            EDGE_RISE: edge_ok = rise;
            EDGE_FALL: edge_ok = fall;
            EDGE_BOTH: edge_ok = rise | fall;
            default:   edge_ok = 1'b0;
        endcase
        cap_hit = run & cfg.en & edge_ok;
        if (sw_we)   st_d.cap = sw_data;
        if (cap_hit) st_d.cap = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap = st_q.cap;
endmodule

// File: rtl/qct_irq.sv
module qct_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic         en_we,
    input  logic [N-1:0] en_val,
    output logic [N-1:0] flags,
    output logic [N-1:0] enables,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] flags;
        logic [N-1:0] en;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic [N-1:0] clr_eff;

    always_comb begin
        st_d       = st_q;
        clr_eff    = clr_we ? clr_mask : '0;
        st_d.flags = (st_q.flags & ~clr_eff) | set;
        if (en_we) st_d.en = en_val;
        irq = |(st_q.flags & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags   = st_q.flags;
    assign enables = st_q.en;
endmodule

// File: rtl/quad_capture_timer.sv
module quad_capture_timer
    import qct_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NCH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic [NCH-1:0]    cap_in,
    input  logic              alt_trig,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int NFLAG = NCH + 1;

    typedef struct packed {
        ctrl_t                 ctrl;
        chan_cfg_t [NCH-1:0]   cfg;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                        cnt_we;
    logic [CNT_W-1:0]            cnt_val;
    logic                        ovf_pulse;
    logic [NCH-1:0]              cap_we;
    logic [NCH-1:0]              cap_rd_sel;
    logic [NCH-1:0]              cap_hit;
    logic [NCH-1:0][CNT_W-1:0]   cap_val;
    logic [NCH-1:0]              chan_pin;
    logic [NFLAG-1:0]            flags;
    logic [NFLAG-1:0]            enables;
    logic                        flag_clr_we;
    logic                        irqen_we;
    logic                        run_w;
    logic                        clr_mode_w;

    // Control and channel configuration registers
    always_comb begin
        st_d = st_q;
        if (reg_we && reg_addr == ADDR_CTRL)
            st_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        if (reg_we && reg_addr == ADDR_CHCFG) begin
            for (int k = 0; k < NCH; k++)
                st_d.cfg[k] = chan_cfg_t'(reg_wdata[CFG_W*k +: CFG_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_w       = st_q.ctrl.run;
    assign clr_mode_w  = st_q.ctrl.clr_match;
    assign cnt_we      = reg_we && (reg_addr == ADDR_COUNT);
    assign flag_clr_we = reg_we && (reg_addr == ADDR_FLAGS);
    assign irqen_we    = reg_we && (reg_addr == ADDR_IRQEN);

    qct_counter #(.W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_w),
        .tick      (cnt_tick),
        .clr_mode  (clr_mode_w),
        .match_val (cap_val[0]),
        .sw_we     (cnt_we),
        .sw_data   (reg_wdata),
        .cnt       (cnt_val),
        .ovf       (ovf_pulse)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        localparam logic [ADDR_W-1:0] CAP_ADDR = ADDR_CAP0 + ADDR_W'(k);

        assign cap_we[k]     = reg_we && (reg_addr == CAP_ADDR);
        assign cap_rd_sel[k] = (reg_addr == CAP_ADDR);

        if (k == 0) begin : g_alt
            assign chan_pin[k] = st_q.ctrl.alt_a ? alt_trig : cap_in[k];
        end else begin : g_pin
            assign chan_pin[k] = cap_in[k];
        end

        qct_cap_chan #(.W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (chan_pin[k]),
            .run     (run_w),
            .cfg     (st_q.cfg[k]),
            .sw_we   (cap_we[k]),
            .sw_data (reg_wdata),
            .cnt     (cnt_val),
            .cap     (cap_val[k]),
            .cap_hit (cap_hit[k])
        );
    end

    qct_irq #(.N(NFLAG)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      ({cap_hit, ovf_pulse}),
        .clr_we   (flag_clr_we),
        .clr_mask (reg_wdata[NFLAG-1:0]),
        .en_we    (irqen_we),
        .en_val   (reg_wdata[NFLAG-1:0]),
        .flags    (flags),
        .enables  (enables),
        .irq      (irq)
    );

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL:  reg_rdata[CTRL_W-1:0]    = st_q.ctrl;
            ADDR_CHCFG: reg_rdata[CFG_W*NCH-1:0] = st_q.cfg;
            ADDR_COUNT: reg_rdata                = cnt_val;
            ADDR_FLAGS: reg_rdata[NFLAG-1:0]     = flags;
            ADDR_IRQEN: reg_rdata[NFLAG-1:0]     = enables;
            default: begin
                for (int k = 0; k < NCH; k++)
                    if (cap_rd_sel[k]) reg_rdata = cap_val[k];
            end
        endcase
    end
endmodule

// File: rtl/qct_checker.sv
module qct_checker #(
    parameter int W = 16,
    parameter int N = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run,
    input logic               clr_mode,
    input logic               tick,
    input logic               cnt_we,
    input logic [W-1:0]       cnt,
    input logic [W-1:0]       match_val,
    input logic [N:0]         flags,
    input logic               flag_clr_we,
    input logic [N-1:0]       cap_we,
    input logic [N-1:0][W-1:0] cap_val
);
    localparam logic [W-1:0] TOP = '1;

    // R2
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> $stable(cnt));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !cnt_we && !(clr_mode && cnt == match_val))
        |=> cnt == $past(cnt) + 1'b1);

    // R4
    match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !cnt_we && clr_mode && cnt == match_val) |=> cnt == '0);

    // R3
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !cnt_we && cnt == TOP && !(clr_mode && match_val == TOP))
        |=> flags[0]);

    // R8
    no_capture_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && cap_we == '0) |=> $stable(cap_val));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr_we |=> (flags & $past(flags)) == $past(flags));
endmodule

bind quad_capture_timer qct_checker #(.W(CNT_W), .N(NCH)) u_qct_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_w),
    .clr_mode    (clr_mode_w),
    .tick        (cnt_tick),
    .cnt_we      (cnt_we),
    .cnt         (cnt_val),
    .match_val   (cap_val[0]),
    .flags       (flags),
    .flag_clr_we (flag_clr_we),
    .cap_we      (cap_we),
    .cap_val     (cap_val)
);

// File: tb/quad_capture_timer_bench.sv
module quad_capture_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic [3:0]  cap_in = 4'b0;
    logic        alt_trig = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    localparam logic [3:0] A_CTRL = 4'd0, A_CFG = 4'd1, A_CNT = 4'd2,
                           A_FLG = 4'd3, A_IEN = 4'd4, A_CAP0 = 4'd8;

    always #5 clk = ~clk;

    quad_capture_timer u_quad_capture_timer (
        .clk (clk), .rst_n (rst_n), .cnt_tick (cnt_tick), .cap_in (cap_in),
        .alt_trig (alt_trig), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq (irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic tick_n(input int n);
        @(negedge clk);
        cnt_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    task automatic pin_set(input int idx, input logic v);
        @(negedge clk);
        cap_in[idx] = v;
        repeat (3) @(posedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(A_CNT, v);  chk("R1 counter", v, 16'h0);
        rd(A_FLG, v);  chk("R1 flags", v, 16'h0);
        rd(A_CAP0, v); chk("R1 capture A", v, 16'h0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 16'h0);
        chk("R1 irq", {15'b0, irq}, 16'h0);
    endtask

    task automatic t_count;
        logic [15:0] v;
        wr(A_CNT, 16'd10);
        wr(A_CTRL, 16'h1);
        tick_n(5);
        rd(A_CNT, v); chk("R2 count 10+5", v, 16'd15);
        wr(A_CTRL, 16'h0);
        tick_n(3);
        rd(A_CNT, v); chk("R2 hold when stopped", v, 16'd15);
    endtask

    task automatic t_overflow;
        logic [15:0] v;
        wr(A_CNT, 16'hFFFE);
        wr(A_CTRL, 16'h1);
        tick_n(2);
        rd(A_CNT, v); chk("R3 wrap to zero", v, 16'h0000);
        rd(A_FLG, v); chk("R3 overflow flag", v, 16'h0001);
        chk("R9 irq masked", {15'b0, irq}, 16'h0);
        wr(A_IEN, 16'h0001);
        #1 chk("R9 irq enabled", {15'b0, irq}, 16'h1);
        wr(A_FLG, 16'h0001);
        rd(A_FLG, v); chk("R9 w1c flags", v, 16'h0);
        chk("R9 irq after clear", {15'b0, irq}, 16'h0);
        wr(A_IEN, 16'h0000);
        wr(A_CTRL, 16'h0);
    endtask

    task automatic t_clear_match;
        logic [15:0] v;
        wr(A_CAP0, 16'd4);
        rd(A_CAP0, v); chk("R10 capture A readback", v, 16'd4);
        wr(A_CNT, 16'd0);
        wr(A_CTRL, 16'h3);
        tick_n(5);
        rd(A_CNT, v); chk("R4 period n+1 back to 0", v, 16'd0);
        tick_n(3);
        rd(A_CNT, v); chk("R4 restart after match", v, 16'd3);
        wr(A_CTRL, 16'h0);
    endtask

    task automatic t_capture_rise;
        logic [15:0] v;
        wr(A_CFG, 16'h0018);            // channel B enabled, rising
        wr(A_CNT, 16'h1234);
        wr(A_CTRL, 16'h1);
        pin_set(1, 1'b1);
        rd(A_CAP0 + 4'd1, v); chk("R5 capture B rising", v, 16'h1234);
        rd(A_FLG, v); chk("R5 flag B", v, 16'h0004);
        wr(A_CNT, 16'h2000);
        pin_set(1, 1'b0);
        rd(A_CAP0 + 4'd1, v); chk("R6 rising-only ignores fall", v, 16'h1234);
        wr(A_FLG, 16'h001F);
    endtask

    task automatic t_edges;
        logic [15:0] v;
        wr(A_CFG, 16'h0F40);            // C falling (101), D both (111), A off
        wr(A_CNT, 16'h0055);
        pin_set(2, 1'b1);
        rd(A_CAP0 + 4'd2, v); chk("R6 falling-only ignores rise", v, 16'h0000);
        wr(A_CNT, 16'h0066);
        pin_set(2, 1'b0);
        rd(A_CAP0 + 4'd2, v); chk("R6 capture C falling", v, 16'h0066);
        wr(A_CNT, 16'h0077);
        pin_set(3, 1'b1);
        rd(A_CAP0 + 4'd3, v); chk("R6 capture D rise", v, 16'h0077);
        wr(A_CNT, 16'h0088);
        pin_set(3, 1'b0);
        rd(A_CAP0 + 4'd3, v); chk("R6 capture D fall", v, 16'h0088);
        pin_set(0, 1'b1);
        pin_set(0, 1'b0);
        rd(A_CAP0, v); chk("R6 disabled channel A", v, 16'd4);
        rd(A_FLG, v); chk("R6 flags C and D only", v, 16'h0018);
        wr(A_FLG, 16'h001F);
        wr(A_CTRL, 16'h0);
    endtask

    task automatic t_stopped;
        logic [15:0] v;
        wr(A_CFG, 16'h0018);
        wr(A_CNT, 16'h0500);
        pin_set(1, 1'b1);
        repeat (2) @(posedge clk);
        rd(A_CAP0 + 4'd1, v); chk("R8 no capture while stopped", v, 16'h1234);
        wr(A_CTRL, 16'h1);
        repeat (4) @(posedge clk);
        rd(A_CAP0 + 4'd1, v); chk("R8 no late capture on resume", v, 16'h1234);
        rd(A_FLG, v); chk("R8 no flag", v, 16'h0000);
        pin_set(1, 1'b0);
        wr(A_CTRL, 16'h0);
    endtask

    task automatic t_alt;
        logic [15:0] v;
        wr(A_CFG, 16'h0003);            // channel A enabled, rising
        wr(A_CTRL, 16'h5);              // run + alternative trigger for A
        wr(A_CNT, 16'h0400);
        pin_set(0, 1'b1);
        rd(A_CAP0, v); chk("R7 pin A ignored", v, 16'd4);
        wr(A_CNT, 16'h0321);
        @(negedge clk); alt_trig = 1'b1;
        repeat (3) @(posedge clk);
        rd(A_CAP0, v); chk("R7 capture on alt trigger", v, 16'h0321);
        rd(A_FLG, v); chk("R7 flag A", v, 16'h0002);
        wr(A_FLG, 16'h001F);
        pin_set(0, 1'b0);
        wr(A_CTRL, 16'h0);
    endtask

    task automatic t_prewrite;
        logic [15:0] v;
        wr(A_CFG, 16'h0E00);            // channel D both edges
        wr(A_CNT, 16'h0AAA);
        wr(A_CTRL, 16'h1);
        @(negedge clk); cap_in[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk); reg_we = 1'b1; reg_addr = A_CNT; reg_wdata = 16'h0BBB;
        @(posedge clk);
        @(negedge clk); reg_we = 1'b0;
        rd(A_CAP0 + 4'd3, v); chk("R10 capture keeps pre-write count", v, 16'h0AAA);
        rd(A_CNT, v); chk("R10 counter takes write", v, 16'h0BBB);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_count();
        t_overflow();
        t_clear_match();
        t_capture_rise();
        t_edges();
        t_stopped();
        t_alt();
        t_prewrite();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule